// File: doc/BRIEF.md
# Multicast Switching Element with Sharer-Pruning Cache

This block is one 4x4 switching element of a network that carries only cache-coherence traffic. Four input ports present invalidation (or update) packets, each holding a line address and the destination bitmap for this element's tree level. A set bit in that bitmap asks for a copy on the matching output port. Every output port shared by several inputs goes to one winner. Each input gets back, in the same cycle, a per-port acknowledge bitmap. The source keeps the packet and resends it on the next frame, aimed only at the ports whose acknowledge bit was 0. One frame equals one clock cycle here.

The coarse header bitmap often reaches ports that hold no copy. To cut that fan-out, the element watches read requests heading towards memory. It keeps, per line address, the exact set of ports that have read the line, in a 256-entry two-way set-associative cache. The first attempt of an invalidation looks up its line. On a hit, the recorded port set replaces the header bitmap and the entry is freed. Resent packets carry their remaining destinations and skip the lookup.

Output ports are valid/ready. An output whose ready is low at a clock edge does not take its copy. The loser of such a port sees a 0 acknowledge for it and resends it. Input ports use the acknowledge bitmap as their handshake: a port is done when all its bits are 1. The read-observe input has no back-pressure.

Top module: `prune_mcast_switch`

## Requirements
- R1: After reset no output is valid and the pruning cache is empty, so the first invalidation of any line uses its header bitmap.
- R2: A read observe (rd_valid, rd_addr, rd_port, port index 0..3) of a line with no entry allocates one holding only bit rd_port.
- R3: A read observe of a line that already has an entry ORs bit rd_port into its recorded port set.
- R4: A first-attempt packet (in_retry=0) whose line hits fans out to exactly the recorded port set, ignoring its header bitmap.
- R5: A first-attempt packet whose line misses fans out to its header bitmap in_map, where bit j asks for output j.
- R6: An entry that served a first-attempt hit is freed at the end of that cycle; a later packet of that line misses.
- R7: A resent packet (in_retry=1) fans out to in_map, does not look up the cache, and does not free any entry.
- R8: When several inputs want one output in a cycle, the lowest input index wins it; out_src gives the winner's index and out_addr its line address.
- R9: in_ack bit j of input i is 1 when input i did not target output j, or won output j while out_ready[j] was 1; otherwise it is 0. An idle input sees all ones.
- R10: An output with out_ready low still shows valid, source and address of its winner, but the winner's acknowledge bit for it is 0.
- R11: The set index is rd_addr bits 6:0; when both ways of a set are valid, a new line replaces the way least recently allocated or read-updated.
- R12: If a read observe and a first-attempt hit on the same line fall in one cycle, the free happens first and the read then allocates a new entry holding only its own port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Packet present on input i |
| in_retry | input | 4 | Packet on input i is a resend |
| in_addr | input | 64 | Line address per input, 16 bits each, input i at bits 16i+15:16i |
| in_map | input | 16 | Destination bitmap per input, input i at bits 4i+3:4i |
| in_ack | output | 16 | Acknowledge bitmap per input, same packing as in_map |
| out_valid | output | 4 | Copy present on output j |
| out_ready | input | 4 | Output j takes its copy |
| out_addr | output | 64 | Line address per output, packed like in_addr |
| out_src | output | 8 | Winning input index per output, 2 bits each |
| rd_valid | input | 1 | A read request of a line was seen |
| rd_addr | input | 16 | Line address of the observed read |
| rd_port | input | 2 | Port the read came from |

## Verification
The bench goes after conflicts among several inputs on overlapping ports. A wrong priority or ack rule would drop a destination for good or deliver it twice. It tests a read observe and a hit on the same line in one cycle. A design that read before it freed would keep the stale sharers and lose the new reader. It fills one set with three lines to test eviction. A wrong LRU bit would throw out the line just touched, and that shows up as header fan-out where a pruned set is expected. It sends resent packets to lines that have entries. A design that looked them up would prune or free wrongly, which shows up when the next first attempt hits the entry.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
  localparam int unsigned PORTS   = 4;
  localparam int unsigned LINE_W  = 16;
  localparam int unsigned N_SETS  = 128;
  localparam int unsigned PID_W   = $clog2(PORTS);
endpackage

// File: rtl/prune_cache.sv
module prune_cache #(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SETS   = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           lk_en,
  input  logic [N*ADDR_W-1:0]    lk_addr,
  output logic [N-1:0]           lk_hit,
  output logic [N*N-1:0]         lk_map,
  input  logic                   rd_valid,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [$clog2(N)-1:0]   rd_port
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - SET_W;

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [N-1:0]     map_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic             lru_q [SETS];

  logic [SET_W-1:0] lk_set [N];
  logic [1:0]       hw     [N];
  logic [N-1:0]     del;
  logic [N-1:0]     del_way;

  for (genvar i = 0; i < N; i++) begin : g_lookup
    logic [ADDR_W-1:0] a;
    assign a         = lk_addr[i*ADDR_W +: ADDR_W];
    assign lk_set[i] = a[SET_W-1:0];
    for (genvar w = 0; w < 2; w++) begin : g_way
      assign hw[i][w] = vld_q[lk_set[i]][w] && (tag_q[lk_set[i]][w] == a[ADDR_W-1:SET_W]);
    end
    assign lk_hit[i]         = |hw[i];
    assign lk_map[i*N +: N]  = hw[i][0] ? map_q[lk_set[i]][0] : map_q[lk_set[i]][1];
    assign del[i]            = lk_en[i] && lk_hit[i];
    assign del_way[i]        = ~hw[i][0];
  end

  logic [SET_W-1:0] r_set;
  logic [TAG_W-1:0] r_tag;
  logic [1:0]       kill, v_eff, r_hit;
  logic             r_way;
  logic [N-1:0]     r_bit;

  assign r_set = rd_addr[SET_W-1:0];
  assign r_tag = rd_addr[ADDR_W-1:SET_W];
  assign r_bit = N'(1) << rd_port;

  always_comb begin
    kill = 2'b00;
    for (int i = 0; i < N; i++)
      if (del[i] && lk_set[i] == r_set) kill[del_way[i]] = 1'b1;
    v_eff = vld_q[r_set] & ~kill;
    for (int w = 0; w < 2; w++)
      r_hit[w] = v_eff[w] && (tag_q[r_set][w] == r_tag);
    if (r_hit[0])       r_way = 1'b0;
    else if (r_hit[1])  r_way = 1'b1;
    else if (!v_eff[0]) r_way = 1'b0;
    else if (!v_eff[1]) r_way = 1'b1;
    else                r_way = lru_q[r_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= 2'b00;
        lru_q[s] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (del[i]) vld_q[lk_set[i]][del_way[i]] <= 1'b0;
      if (rd_valid) begin
        vld_q[r_set][r_way] <= 1'b1;
        tag_q[r_set][r_way] <= r_tag;
        map_q[r_set][r_way] <= (|r_hit) ? (map_q[r_set][r_way] | r_bit) : r_bit;
        lru_q[r_set]        <= ~r_way;
      end
    end
  end

  // checker state: where the last read and the last port-0 free landed
  logic             rchk_q, dchk_q, rway_q, dway_q;
  logic [SET_W-1:0] rset_q, dset_q;
  logic [N-1:0]     rbit_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rchk_q <= 1'b0; dchk_q <= 1'b0; rway_q <= 1'b0; dway_q <= 1'b0;
      rset_q <= '0;   dset_q <= '0;   rbit_q <= '0;
    end else begin
      rchk_q <= rd_valid;
      rset_q <= r_set; rway_q <= r_way; rbit_q <= r_bit;
      dchk_q <= del[0] && !(rd_valid && r_set == lk_set[0] && r_way == del_way[0]);
      dset_q <= lk_set[0]; dway_q <= del_way[0];
    end
  end

  assert_read_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rchk_q |-> (vld_q[rset_q][rway_q] && ((map_q[rset_q][rway_q] & rbit_q) == rbit_q)));

  assert_hit_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dchk_q |-> !vld_q[dset_q][dway_q]);
endmodule

// File: rtl/mcast_arbiter.sv
module mcast_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N*N-1:0]          req,
  output logic [N*N-1:0]          gnt,
  output logic [N-1:0]            any,
  output logic [N*$clog2(N)-1:0]  src
);
  localparam int unsigned IW = $clog2(N);

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [IW-1:0] win;
    logic [N-1:0]  col;
    always_comb begin
      win = '0;
      col = '0;
      for (int i = N - 1; i >= 0; i--)
        col[i] = req[i*N + j];
      for (int i = N - 1; i >= 0; i--)
        if (col[i]) win = IW'(i);
    end
    assign any[j]            = |col;
    assign src[j*IW +: IW]   = win;
    for (genvar i = 0; i < N; i++) begin : g_g
      assign gnt[i*N + j] = any[j] && (win == IW'(i));
    end

    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any[j] |-> (col[win] && ((col & ((N'(1) << win) - N'(1))) == '0)));
  end
endmodule

// File: rtl/prune_mcast_switch.sv
module prune_mcast_switch
  import mcast_pkg::*;
#(
  parameter int unsigned N      = PORTS,
  parameter int unsigned ADDR_W = LINE_W,
  parameter int unsigned SETS   = N_SETS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            in_valid,
  input  logic [N-1:0]            in_retry,
  input  logic [N*ADDR_W-1:0]     in_addr,
  input  logic [N*N-1:0]          in_map,
  output logic [N*N-1:0]          in_ack,
  output logic [N-1:0]            out_valid,
  input  logic [N-1:0]            out_ready,
  output logic [N*ADDR_W-1:0]     out_addr,
  output logic [N*$clog2(N)-1:0]  out_src,
  input  logic                    rd_valid,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [$clog2(N)-1:0]    rd_port
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]   lk_en, lk_hit;
  logic [N*N-1:0] lk_map, req, gnt;

  assign lk_en = in_valid & ~in_retry;

  prune_cache #(.N(N), .ADDR_W(ADDR_W), .SETS(SETS)) i_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_addr(in_addr), .lk_hit(lk_hit), .lk_map(lk_map),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_port(rd_port)
  );

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0] fan;
    assign fan = (lk_en[i] && lk_hit[i]) ? lk_map[i*N +: N] : in_map[i*N +: N];
    assign req[i*N +: N]    = in_valid[i] ? fan : '0;
    assign in_ack[i*N +: N] = ~req[i*N +: N] | (gnt[i*N +: N] & out_ready);
  end

  mcast_arbiter #(.N(N)) i_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .any(out_valid), .src(out_src)
  );

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [IW-1:0] s;
    assign s = out_src[j*IW +: IW];
    assign out_addr[j*ADDR_W +: ADDR_W] = in_addr[s*ADDR_W +: ADDR_W];

    assert_winner_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> in_valid[s]);
    assert_taken_acked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && out_ready[j]) |-> in_ack[s*N + j]);
    assert_stalled_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && !out_ready[j]) |-> !in_ack[s*N + j]);
  end
endmodule

// File: tb/test_prune_mcast_switch.sv
module test_prune_mcast_switch;
  localparam int N = 4;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    iv, ir, ordy;
  logic [AW-1:0]   ia [N];
  logic [N-1:0]    im [N];
  logic            rv;
  logic [AW-1:0]   ra;
  logic [1:0]      rp;

  logic [N*AW-1:0] in_addr_f;
  logic [N*N-1:0]  in_map_f, ack_f;
  logic [N-1:0]    ov;
  logic [N*AW-1:0] oa_f;
  logic [N*2-1:0]  os_f;

  for (genvar k = 0; k < N; k++) begin : g_pack
    assign in_addr_f[k*AW +: AW] = ia[k];
    assign in_map_f[k*N +: N]    = im[k];
  end

  prune_mcast_switch i_prune_mcast_switch (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv), .in_retry(ir), .in_addr(in_addr_f), .in_map(in_map_f),
    .in_ack(ack_f), .out_valid(ov), .out_ready(ordy), .out_addr(oa_f), .out_src(os_f),
    .rd_valid(rv), .rd_addr(ra), .rd_port(rp)
  );

  typedef struct { int unsigned addr; logic [3:0] map; } ent_t;
  ent_t model [128][$];   // front = most recently used
  int checks = 0;
  int fails  = 0;

  function automatic int find(int s, int unsigned a);
    for (int k = 0; k < model[s].size(); k++)
      if (model[s][k].addr == a) return k;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    iv = '0; ir = '0; ordy = '1; rv = 1'b0; ra = '0; rp = '0;
    for (int k = 0; k < N; k++) begin ia[k] = '0; im[k] = '0; end
  endtask

  // compare outputs to the model for the current inputs, then advance the model and the clock
  task automatic cycle(input string tag);
    logic [3:0]  fan [N];
    int unsigned dels [$];
    #1;
    for (int i = 0; i < N; i++) begin
      fan[i] = im[i];
      if (iv[i] && !ir[i]) begin
        int s = int'(ia[i]) % 128;
        int k = find(s, ia[i]);
        if (k >= 0) begin fan[i] = model[s][k].map; dels.push_back(ia[i]); end
      end
      if (!iv[i]) fan[i] = '0;
    end
    for (int j = 0; j < N; j++) begin
      int w = -1;
      for (int i = N - 1; i >= 0; i--) if (fan[i][j]) w = i;
      chk(tag, $sformatf("out_valid[%0d]", j), int'(ov[j]), int'(w >= 0));
      if (w >= 0) begin
        chk(tag, $sformatf("out_src[%0d]", j), int'(os_f[j*2 +: 2]), w);
        chk(tag, $sformatf("out_addr[%0d]", j), int'(oa_f[j*AW +: AW]), int'(ia[w]));
      end
    end
    for (int i = 0; i < N; i++) begin
      logic [3:0] e;
      for (int j = 0; j < N; j++) begin
        int w = -1;
        for (int q = N - 1; q >= 0; q--) if (fan[q][j]) w = q;
        e[j] = !fan[i][j] || (w == i && ordy[j]);
      end
      chk(tag, $sformatf("in_ack[%0d]", i), int'(ack_f[i*N +: N]), int'(e));
    end
    foreach (dels[d]) begin
      int s = int'(dels[d]) % 128;
      int k = find(s, dels[d]);
      if (k >= 0) model[s].delete(k);
    end
    if (rv) begin
      int s = int'(ra) % 128;
      int k = find(s, ra);
      ent_t e;
      if (k >= 0) begin
        e = model[s][k];
        e.map = e.map | (4'b1 << rp);
        model[s].delete(k);
      end else begin
        e.addr = ra; e.map = 4'b1 << rp;
        if (model[s].size() == 2) void'(model[s].pop_back());
      end
      model[s].push_front(e);
    end
    @(negedge clk);
  endtask

  task automatic send(input int i, input logic [AW-1:0] a, input logic [3:0] m, input logic retry);
    iv[i] = 1'b1; ia[i] = a; im[i] = m; ir[i] = retry;
  endtask

  task automatic read(input logic [AW-1:0] a, input logic [1:0] p);
    rv = 1'b1; ra = a; rp = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs, empty cache uses the header
    cycle("R1");
    send(0, 16'h0105, 4'b1111, 1'b0); cycle("R1");
    // R2 then R4 then R6
    clear_in(); read(16'h0105, 2'd2); cycle("R2");
    clear_in(); send(0, 16'h0105, 4'b1111, 1'b0); cycle("R4");
    clear_in(); send(1, 16'h0105, 4'b1011, 1'b0); cycle("R6");
    // R3: sharers accumulate
    clear_in(); read(16'h0105, 2'd1); cycle("R2");
    clear_in(); read(16'h0105, 2'd3); cycle("R3");
    clear_in(); send(2, 16'h0105, 4'b0001, 1'b0); cycle("R3");
    // R7: resend skips lookup and keeps the entry; R5 miss
    clear_in(); read(16'h0203, 2'd0); cycle("R2");
    clear_in(); send(0, 16'h0203, 4'b0110, 1'b1); cycle("R7");
    clear_in(); send(0, 16'h0203, 4'b0110, 1'b0); cycle("R7");
    clear_in(); send(3, 16'h0777, 4'b0101, 1'b0); cycle("R5");
    // R8 and R9: three inputs fight for overlapping ports
    clear_in();
    send(0, 16'h0011, 4'b0011, 1'b1);
    send(1, 16'h0022, 4'b0110, 1'b1);
    send(2, 16'h0033, 4'b1111, 1'b1);
    cycle("R8");
    send(1, 16'h0022, 4'b0100, 1'b1);
    send(2, 16'h0033, 4'b1100, 1'b1);
    ia[0] = 16'h0044; im[0] = 4'b0000; cycle("R9");
    // R10: stalled outputs
    clear_in(); ordy = 4'b1010;
    send(0, 16'h0055, 4'b1111, 1'b1); send(3, 16'h0066, 4'b0001, 1'b1); cycle("R10");
    // R11: fill set 5 and evict the least recent line
    clear_in(); read(16'h0005, 2'd0); cycle("R11");
    clear_in(); read(16'h0085, 2'd1); cycle("R11");
    clear_in(); read(16'h0005, 2'd3); cycle("R11");
    clear_in(); read(16'h0185, 2'd2); cycle("R11");
    clear_in(); send(0, 16'h0085, 4'b1111, 1'b0); cycle("R11");
    clear_in(); send(0, 16'h0005, 4'b1111, 1'b0); cycle("R11");
    clear_in(); send(1, 16'h0185, 4'b1111, 1'b0); cycle("R11");
    // R12: free then allocate in one cycle
    clear_in(); read(16'h0300, 2'd1); cycle("R12");
    clear_in(); send(0, 16'h0300, 4'b1111, 1'b0); read(16'h0300, 2'd3); cycle("R12");
    clear_in(); send(0, 16'h0300, 4'b1111, 1'b0); cycle("R12");
    // mixed traffic over a small pool of lines sharing sets
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      ordy = 4'($urandom);
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 2) != 0)
          send(i, 16'h0009 + 16'(($urandom_range(0, 5)) * 128), 4'($urandom), 1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 1) != 0)
        read(16'h0009 + 16'(($urandom_range(0, 5)) * 128), 2'($urandom));
      cycle("R9");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule